// File: doc/BRIEF.md
# Conditional-Flag Integer ALU

A purely combinational data-processing unit for the execute stage of a classic 32-bit RISC pipeline. Each evaluation takes a 4-bit operation code, two operands (the second one already passed through the shifter or the immediate rotator), the shifter's carry-out, and the current condition flags. It returns a result word, an indication of whether that result is to be written to a register, and the next value of the four condition flags N, Z, C and V.

Sixteen operations are covered. These are bitwise logic, moves, forward and reversed subtraction, addition, and carry-chained forms of each. Four compare-only forms produce flags but request no register write. Logic and move operations take their carry from the shifter path rather than from the adder, and leave the overflow flag alone. Subtraction uses the inverted-borrow convention, in which a set carry means that no borrow occurred. Flags change only when the set-flags input is high. Otherwise the incoming flags pass straight through.

The barrel shifter, register file, predication and multiply are outside this block. A parameter selects either a single ripple adder or a carry-select adder split into two halves.

Top module: `cond_flag_alu`

## Requirements
- R1: Opcodes 0x0 AND, 0x1 XOR, 0x8 test-AND, 0x9 test-XOR, 0xC OR, 0xD MOVE (second operand), 0xE bit-clear (first AND NOT second) and 0xF MOVE-NOT (NOT second) drive `result` with that bitwise value.
- R2: Opcodes 0x2 SUB (first − second), 0x3 reverse SUB (second − first), 0x4 ADD, 0xA compare (first − second) and 0xB compare-negative (first + second) drive `result` with the 32-bit wrapped value.
- R3: Opcode 0x5 gives first + second + C, 0x6 gives first − second − NOT(C), and 0x7 gives second − first − NOT(C), where C is `flags_in[1]`.
- R4: `write_en` is 0 for opcodes 0x8 to 0xB and 1 for every other opcode, whatever the value of `set_flags`.
- R5: When flags are set by an arithmetic opcode (0x2 to 0x7, 0xA, 0xB), C is the unsigned carry out (for subtraction: 1 when no borrow occurs), and V is 1 exactly when the true signed result does not fit in 32 bits.
- R6: When flags are set by a logical opcode and `imm_operand` is 0, C takes the value of `shift_carry` and V keeps `flags_in[0]`.
- R7: When flags are set by a logical opcode and `imm_operand` is 1, C takes `shift_carry` if `rot_nonzero` is 1 and otherwise keeps `flags_in[1]`.
- R8: When `set_flags` is 1, N (`flags_out[3]`) equals `result[31]` and Z (`flags_out[2]`) is 1 exactly when `result` is zero, for every opcode.
- R9: When `set_flags` is 0, `flags_out` equals `flags_in` for every opcode. The flag bits are ordered N, Z, C, V from bit 3 down to bit 0, which matches status-word bits 31 to 28.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, after the shifter or the rotator |
| shift_carry | input | 1 | Carry-out of the shifter or the immediate rotator |
| imm_operand | input | 1 | Second operand is a rotated immediate |
| rot_nonzero | input | 1 | The immediate rotate amount is nonzero |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| set_flags | input | 1 | Update the flags from this operation |
| result | output | 32 | Computed value (also driven for compare forms) |
| write_en | output | 1 | Result is to be written to the destination register |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
Directed vectors come first. They hit the carry and overflow boundaries of each arithmetic form: equal operands, 0x7FFFFFFF against 0x80000000, all-ones plus one, and a zero result. Each of these is applied with the incoming carry both clear and set, which separates the inverted-borrow convention from a plain borrow and shows whether the carry-in is used at all. The logical forms are then run with the shifter carry opposite to the incoming carry, under register, zero-rotate immediate and nonzero-rotate immediate operands, so that each carry source is seen. A long pseudo-random phase biases the operands toward sign boundaries and equal values, and toggles set-flags so that the flag-hold path is compared against the update path.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'h0, OP_XOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
      OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
      OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
      OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
   } op_e;

   typedef enum logic [1:0] {
      CIN_ZERO = 2'd0,
      CIN_ONE  = 2'd1,
      CIN_FLAG = 2'd2
   } cin_sel_e;

   typedef struct packed {
      logic     is_arith;
      logic     swap;
      logic     inv_y;
      cin_sel_e cin_sel;
      logic     writes;
   } ctl_t;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   localparam int FLAG_BITS = 4;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
   import alu_pkg::*;
(
   input  logic [3:0] op,
   output ctl_t       ctl
);

   always_comb begin
      ctl = '{is_arith: 1'b0, swap: 1'b0, inv_y: 1'b0,
              cin_sel: CIN_ZERO, writes: 1'b1};
      unique case (op_e'(op))
         OP_SUB, OP_CMP: begin
            ctl.is_arith = 1'b1;
            ctl.inv_y    = 1'b1;
            ctl.cin_sel  = CIN_ONE;
         end
         OP_RSB: begin
            ctl.is_arith = 1'b1;
            ctl.swap     = 1'b1;
            ctl.inv_y    = 1'b1;
            ctl.cin_sel  = CIN_ONE;
         end
         OP_ADD, OP_CMN: begin
            ctl.is_arith = 1'b1;
         end
         OP_ADC: begin
            ctl.is_arith = 1'b1;
            ctl.cin_sel  = CIN_FLAG;
         end
         OP_SBC: begin
            ctl.is_arith = 1'b1;
            ctl.inv_y    = 1'b1;
            ctl.cin_sel  = CIN_FLAG;
         end
         OP_RSC: begin
            ctl.is_arith = 1'b1;
            ctl.swap     = 1'b1;
            ctl.inv_y    = 1'b1;
            ctl.cin_sel  = CIN_FLAG;
         end
         default: ;
      endcase
      if (op[3:2] == 2'b10) ctl.writes = 1'b0;
   end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH = 32,
   parameter bit SPLIT = 1'b0
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);

   localparam int LO = WIDTH / 2;
   localparam int HI = WIDTH - LO;

   generate
      if (WIDTH < 4) begin : g_width_bad
         $error("alu_adder: WIDTH must be at least 4");
      end

      if (!SPLIT) begin : g_ripple
         logic [WIDTH:0] full;
         always_comb full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
         assign sum  = full[WIDTH-1:0];
         assign cout = full[WIDTH];
      end else begin : g_csel
         logic [LO:0] lo_sum;
         logic [HI:0] hi_c0;
         logic [HI:0] hi_c1;
         always_comb begin
            lo_sum = {1'b0, x[LO-1:0]} + {1'b0, y[LO-1:0]} + {{LO{1'b0}}, cin};
            hi_c0  = {1'b0, x[WIDTH-1:LO]} + {1'b0, y[WIDTH-1:LO]};
            hi_c1  = {1'b0, x[WIDTH-1:LO]} + {1'b0, y[WIDTH-1:LO]} + {{HI{1'b0}}, 1'b1};
         end
         assign sum  = lo_sum[LO] ? {hi_c1[HI-1:0], lo_sum[LO-1:0]}
                                  : {hi_c0[HI-1:0], lo_sum[LO-1:0]};
         assign cout = lo_sum[LO] ? hi_c1[HI] : hi_c0[HI];
      end
   endgenerate

   assign ovf = (x[WIDTH-1] == y[WIDTH-1]) && (sum[WIDTH-1] != x[WIDTH-1]);

endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] y
);

   always_comb begin
      unique case (op_e'(op))
         OP_AND, OP_TST: y = a & b;
         OP_XOR, OP_TEQ: y = a ^ b;
         OP_ORR:         y = a | b;
         OP_MOV:         y = b;
         OP_BIC:         y = a & ~b;
         OP_MVN:         y = ~b;
         default:        y = '0;
      endcase
   end

endmodule

// File: rtl/alu_flags.sv
module alu_flags
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             is_arith,
   input  logic [WIDTH-1:0] res,
   input  logic             add_cout,
   input  logic             add_ovf,
   input  logic             shift_carry,
   input  logic             imm_operand,
   input  logic             rot_nonzero,
   input  logic             set_flags,
   input  flags_t           fin,
   output flags_t           fout
);

   logic logic_c;

   always_comb begin
      if (imm_operand && !rot_nonzero) logic_c = fin.c;
      else                             logic_c = shift_carry;
   end

   always_comb begin
      fout = fin;
      if (set_flags) begin
         fout.n = res[WIDTH-1];
         fout.z = (res == '0);
         fout.c = is_arith ? add_cout : logic_c;
         fout.v = is_arith ? add_ovf  : fin.v;
      end
   end

endmodule

// File: rtl/cond_flag_alu.sv
module cond_flag_alu
   import alu_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter bit ADDER_SPLIT  = 1'b0
) (
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic             shift_carry,
   input  logic             imm_operand,
   input  logic             rot_nonzero,
   input  logic [3:0]       flags_in,
   input  logic             set_flags,
   output logic [WIDTH-1:0] result,
   output logic             write_en,
   output logic [3:0]       flags_out
);

   generate
      if (FLAG_BITS != 4) begin : g_flag_bad
         $error("cond_flag_alu: flag vector must be four bits");
      end
   endgenerate

   ctl_t             ctl;
   logic [WIDTH-1:0] add_x;
   logic [WIDTH-1:0] add_y;
   logic             add_cin;
   logic [WIDTH-1:0] add_sum;
   logic             add_cout;
   logic             add_ovf;
   logic [WIDTH-1:0] log_res;
   flags_t           fin;
   flags_t           fout;

   assign fin = flags_t'(flags_in);

   alu_decode u_dec (
      .op  (op),
      .ctl (ctl)
   );

   always_comb begin
      add_x = ctl.swap ? opnd_b : opnd_a;
      add_y = ctl.swap ? opnd_a : opnd_b;
      if (ctl.inv_y) add_y = ~add_y;
      unique case (ctl.cin_sel)
         CIN_ONE:  add_cin = 1'b1;
         CIN_FLAG: add_cin = fin.c;
         default:  add_cin = 1'b0;
      endcase
   end

   alu_adder #(.WIDTH(WIDTH), .SPLIT(ADDER_SPLIT)) u_add (
      .x    (add_x),
      .y    (add_y),
      .cin  (add_cin),
      .sum  (add_sum),
      .cout (add_cout),
      .ovf  (add_ovf)
   );

   alu_logic #(.WIDTH(WIDTH)) u_log (
      .op (op),
      .a  (opnd_a),
      .b  (opnd_b),
      .y  (log_res)
   );

   assign result = ctl.is_arith ? add_sum : log_res;

   alu_flags #(.WIDTH(WIDTH)) u_flg (
      .is_arith    (ctl.is_arith),
      .res         (result),
      .add_cout    (add_cout),
      .add_ovf     (add_ovf),
      .shift_carry (shift_carry),
      .imm_operand (imm_operand),
      .rot_nonzero (rot_nonzero),
      .set_flags   (set_flags),
      .fin         (fin),
      .fout        (fout)
   );

   assign write_en  = ctl.writes;
   assign flags_out = fout;

endmodule

// File: rtl/cond_flag_alu_chk.sv
module cond_flag_alu_chk #(
   parameter int WIDTH = 32
) (
   input logic [3:0]       op,
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic             shift_carry,
   input logic             imm_operand,
   input logic             rot_nonzero,
   input logic [3:0]       flags_in,
   input logic             set_flags,
   input logic [WIDTH-1:0] result,
   input logic             write_en,
   input logic [3:0]       flags_out
);

   logic is_logic;
   assign is_logic = (op <= 4'h1) || (op == 4'h8) || (op == 4'h9) || (op >= 4'hC);

   always_comb begin
      // R4
      cmp_nowrite_chk: assert (!(op[3:2] == 2'b10 && write_en));
      // R9
      hold_flags_chk: assert (set_flags || flags_out == flags_in);
      // R8
      zero_flag_chk: assert (!set_flags || (flags_out[2] == (result == '0)));
      // R8
      neg_flag_chk: assert (!set_flags || (flags_out[3] == result[WIDTH-1]));
      // R6
      logic_v_keep_chk: assert (!(set_flags && is_logic) || flags_out[0] == flags_in[0]);
      // R7
      imm_keep_c_chk: assert (!(set_flags && is_logic && imm_operand && !rot_nonzero)
                              || flags_out[1] == flags_in[1]);
      // R6
      reg_shift_c_chk: assert (!(set_flags && is_logic && !imm_operand)
                               || flags_out[1] == shift_carry);
      // R5
      sub_carry_chk: assert (!(set_flags && op == 4'h2) || flags_out[1] == (opnd_a >= opnd_b));
   end

endmodule

bind cond_flag_alu cond_flag_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .op          (op),
   .opnd_a      (opnd_a),
   .opnd_b      (opnd_b),
   .shift_carry (shift_carry),
   .imm_operand (imm_operand),
   .rot_nonzero (rot_nonzero),
   .flags_in    (flags_in),
   .set_flags   (set_flags),
   .result      (result),
   .write_en    (write_en),
   .flags_out   (flags_out)
);

// File: tb/test_cond_flag_alu.sv
module test_cond_flag_alu;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op;
   logic [31:0] opnd_a, opnd_b;
   logic        shift_carry, imm_operand, rot_nonzero, set_flags;
   logic [3:0]  flags_in;
   logic [31:0] result;
   logic        write_en;
   logic [3:0]  flags_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cond_flag_alu i_cond_flag_alu (
      .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .shift_carry(shift_carry),
      .imm_operand(imm_operand), .rot_nonzero(rot_nonzero), .flags_in(flags_in),
      .set_flags(set_flags), .result(result), .write_en(write_en), .flags_out(flags_out)
   );

   // reference model outputs
   logic [31:0] e_res;
   logic        e_wr;
   logic [3:0]  e_flags;
   bit          e_arith;

   function automatic bit fits32(longint v);
      return (v >= -64'sd2147483648) && (v <= 64'sd2147483647);
   endfunction

   task automatic model();
      longint ua, ub, sa, sb, nb, full;
      logic c, cc, vv;
      ua = longint'(opnd_a); ub = longint'(opnd_b);
      sa = longint'($signed(opnd_a)); sb = longint'($signed(opnd_b));
      c  = flags_in[1];
      nb = c ? 0 : 1;
      e_arith = 1'b1; cc = 1'b0; vv = 1'b0;
      case (op)
         4'h2, 4'hA: begin e_res = opnd_a - opnd_b; cc = (ua >= ub); vv = !fits32(sa - sb); end
         4'h3:       begin e_res = opnd_b - opnd_a; cc = (ub >= ua); vv = !fits32(sb - sa); end
         4'h4, 4'hB: begin full = ua + ub; e_res = full[31:0]; cc = full > 64'hFFFFFFFF; vv = !fits32(sa + sb); end
         4'h5:       begin full = ua + ub + (c ? 1 : 0); e_res = full[31:0];
                           cc = full > 64'hFFFFFFFF; vv = !fits32(sa + sb + (c ? 1 : 0)); end
         4'h6:       begin full = ua - ub - nb; e_res = full[31:0];
                           cc = (ua >= ub + nb); vv = !fits32(sa - sb - nb); end
         4'h7:       begin full = ub - ua - nb; e_res = full[31:0];
                           cc = (ub >= ua + nb); vv = !fits32(sb - sa - nb); end
         default: begin
            e_arith = 1'b0;
            case (op)
               4'h0, 4'h8: e_res = opnd_a & opnd_b;
               4'h1, 4'h9: e_res = opnd_a ^ opnd_b;
               4'hC:       e_res = opnd_a | opnd_b;
               4'hD:       e_res = opnd_b;
               4'hE:       e_res = opnd_a & ~opnd_b;
               default:    e_res = ~opnd_b;
            endcase
            cc = imm_operand ? (rot_nonzero ? shift_carry : c) : shift_carry;
            vv = flags_in[0];
         end
      endcase
      e_wr = !(op >= 4'h8 && op <= 4'hB);
      if (set_flags) e_flags = {e_res[31], e_res == 32'h0, cc, vv};
      else           e_flags = flags_in;
   endtask

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s op=%h a=%h b=%h: actual %h expected %h",
                  tag, what, op, opnd_a, opnd_b, act, exp);
      end
   endtask

   task automatic compare();
      string rtag, ctag, vtag;
      model();
      if (e_arith) rtag = (op >= 4'h5 && op <= 4'h7) ? "R3" : "R2";
      else         rtag = "R1";
      chk(rtag, "result", result, e_res);
      chk("R4", "write_en", {31'h0, write_en}, {31'h0, e_wr});
      if (!set_flags) begin
         chk("R9", "flags", {28'h0, flags_out}, {28'h0, e_flags});
      end else begin
         ctag = e_arith ? "R5" : (imm_operand ? "R7" : "R6");
         vtag = e_arith ? "R5" : "R6";
         chk("R8", "N", {31'h0, flags_out[3]}, {31'h0, e_flags[3]});
         chk("R8", "Z", {31'h0, flags_out[2]}, {31'h0, e_flags[2]});
         chk(ctag, "C", {31'h0, flags_out[1]}, {31'h0, e_flags[1]});
         chk(vtag, "V", {31'h0, flags_out[0]}, {31'h0, e_flags[0]});
      end
   endtask

   task automatic apply(logic [3:0] o, logic [31:0] a, logic [31:0] b, logic sc,
                        logic im, logic rn, logic [3:0] fi, logic sf);
      @(posedge clk);
      op = o; opnd_a = a; opnd_b = b; shift_carry = sc;
      imm_operand = im; rot_nonzero = rn; flags_in = fi; set_flags = sf;
      @(negedge clk);
      compare();
   endtask

   function automatic logic [31:0] pick();
      case ($urandom_range(0, 7))
         0: return 32'h0;
         1: return 32'h8000_0000;
         2: return 32'h7FFF_FFFF;
         3: return 32'hFFFF_FFFF;
         4: return 32'h1;
         default: return $urandom();
      endcase
   endfunction

   initial begin
      op = 4'h0; opnd_a = '0; opnd_b = '0; shift_carry = 1'b0;
      imm_operand = 1'b0; rot_nonzero = 1'b0; flags_in = 4'h0; set_flags = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // quiescent state: all-zero inputs (R1, R4, R9)
      @(negedge clk);
      compare();
      // R2/R5 boundaries, both incoming carries; R3 carry-in conventions
      for (int f = 0; f < 2; f++) begin
         for (int o = 2; o <= 11; o++) begin
            if (o >= 8 && o <= 9) continue;
            apply(4'(o), 32'h0000_0005, 32'h0000_0005, 1'b0, 1'b0, 1'b0, {2'b00, f[0], 1'b0}, 1'b1);
            apply(4'(o), 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 1'b0, 1'b0, {2'b00, f[0], 1'b1}, 1'b1);
            apply(4'(o), 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 1'b0, {2'b01, f[0], 1'b0}, 1'b1);
            apply(4'(o), 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0, {2'b10, f[0], 1'b0}, 1'b1);
            apply(4'(o), 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b0, 1'b0, {2'b00, f[0], 1'b1}, 1'b1);
         end
      end
      // R6/R7: logical ops with shifter carry opposite to incoming carry
      for (int o = 0; o < 16; o++) begin
         if (o >= 2 && o <= 7) continue;
         if (o == 10 || o == 11) continue;
         for (int m = 0; m < 3; m++) begin
            apply(4'(o), 32'hF0F0_1234, 32'h0FF0_8001, 1'b1, m != 0, m == 2, 4'b0001, 1'b1);
            apply(4'(o), 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, m != 0, m == 2, 4'b1110, 1'b1);
         end
      end
      // R9: set_flags low holds every flag pattern
      for (int fl = 0; fl < 16; fl++)
         apply(4'(fl), 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 4'(fl), 1'b0);
      // pseudo-random phase
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] ra;
         ra = pick();
         apply(4'($urandom_range(0, 15)), ra, ($urandom_range(0, 5) == 0) ? ra : pick(),
               1'($urandom()), 1'($urandom()), 1'($urandom()), 4'($urandom()),
               $urandom_range(0, 3) != 0);
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int cyc = 0; cyc < WATCHDOG; cyc++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule